// File: doc/BRIEF.md
# Multi-Mode Multicart PRG Bank Mapper

This block steers the program-ROM bank lines of a cartridge for an 8-bit console CPU. One datapath stands in for several discrete-logic bank-switching schemes. A menu program picks the scheme per game, and the game then runs as if its own simple mapper were fitted. The CPU programs three registers: a mode byte, an outer bank and an inner (current) bank. For each read in the $8000-$FFFF window the block forms the 16 KiB ROM bank number from those registers and CPU A14.

CPU writes are handled in two steps. A write to $5000-$5FFF sets a target selector. A write anywhere in $8000-$FFFF then stores the CPU data byte into the selected register. The stored value is always the byte the CPU drives, so a ROM byte at the written address has no effect on it. A small bus state machine tracks each M2 pulse. Its states are BUS_IDLE (M2 low), BUS_ACTIVE (M2 high, address and data being sampled) and BUS_APPLY (one cycle in which the sampled write is committed). Its transitions are: IDLE→ACTIVE on M2 high; ACTIVE→APPLY on M2 low after a write; ACTIVE→IDLE on M2 low after a read; APPLY→ACTIVE on M2 high; APPLY→IDLE on M2 low. Inputs are taken as synchronous to `clk`. At power-on every register bit is set to one, so the last ROM bank sits at $C000-$FFFF.

Top module: `multimode_prg_mapper`

## Requirements
- R1: After reset every register bit is one: with default BANK_W=8 both $8000 and $C000 read bank $FF, and the target selector points at the outer bank.
- R2: A committed write to $5000-$5FFF loads the selector from data bits 7 and 0: 01 = inner bank, 10 = mode, 11 = outer bank. A committed write to $8000-$FFFF stores into the selected register.
- R3: The mode byte keeps bits 5:4 as outer size (0=32K, 1=64K, 2=128K, 3=256K) and bits 3:2 as PRG mode. In PRG mode 3, $8000-$BFFF is switched and $C000-$FFFF is fixed at bank {outer,1}.
- R4: In PRG mode 2, $8000-$BFFF is fixed at bank {outer,0} and $C000-$FFFF is switched.
- R5: In PRG modes 0 and 1 both halves are switched as a 32 KiB unit, and the value merged in is {inner,A14}.
- R6: In a switched slot the bank is {outer,0}, with its low 1, 2, 3 or 4 bits (sizes 32K..256K) replaced by the same bits of the merged value. In PRG modes 2/3 that value is the inner bank.
- R7: With mode $3C and outer $2A, inner values 0..15 map $8000 to banks $50..$5F, and $C000 always reads bank $55.
- R8: With mode $3C and outer $2F, $C000 reads bank $5F.
- R9: A write takes effect only after M2 falls with R/W low, and it is visible two clocks after the low M2 is sampled. While M2 is still high the mapping is unchanged. Read cycles and writes to $6000-$7FFF or below $5000 change nothing.
- R10: The stored value is the CPU data byte: writing $FF at $FFF6 loads $FF regardless of the ROM contents there.
- R11: With selector 00 (data bits 7 and 0 both clear), writes to $8000-$FFFF change no register.
- R12: The inner bank keeps only data bits 3:0. Its upper data bits are ignored.
- R13: The outer bank keeps only data bits BANK_W-2:0 (6:0 by default). The higher bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; CPU bus inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low power-on reset; sets all register bits to one |
| cpu_addr_hi | input | 4 | CPU address lines A15..A12 |
| cpu_data | input | 8 | CPU data bus |
| cpu_rw | input | 1 | CPU read/write, low for a write |
| cpu_m2 | input | 1 | CPU bus phase qualifier; writes commit on its falling edge |
| rom_bank | output | BANK_W | 16 KiB ROM bank number for the current access |

## Verification
Two functions can fall in the same cycle: the bank lookup for the address on the bus, and a write in progress to that same region, which is about to change the mapping. The bench starts a data write at $8000-$FFFF and samples the bank output while M2 is still high. It expects the old mapping there, and expects the new mapping only once the commit has passed. Every lookup after a write is judged against a model built from the requirements, using the register values the bench believes it wrote.

// File: rtl/mmap_pkg.sv
package mmap_pkg;

    localparam int DATA_W = 8;
    localparam logic [3:0] SEL_PAGE = 4'h5;

    typedef enum logic [1:0] {
        PRG_32K_A  = 2'd0,
        PRG_32K_B  = 2'd1,
        PRG_FIX_LO = 2'd2,
        PRG_FIX_HI = 2'd3
    } prg_mode_e;

    typedef enum logic [1:0] {
        BUS_IDLE   = 2'd0,
        BUS_ACTIVE = 2'd1,
        BUS_APPLY  = 2'd2
    } bus_state_e;

    // encoding is {data bit 7, data bit 0} of the selector write
    typedef enum logic [1:0] {
        TGT_NONE  = 2'b00,
        TGT_INNER = 2'b01,
        TGT_MODE  = 2'b10,
        TGT_OUTER = 2'b11
    } reg_target_e;

endpackage

// File: rtl/mmap_bus_fsm.sv
module mmap_bus_fsm
    import mmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        cpu_addr_hi,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic              cpu_rw,
    input  logic              cpu_m2,
    output bus_state_e        bus_st,
    output logic              sel_we,
    output logic              data_we,
    output logic [DATA_W-1:0] wr_data
);

    bus_state_e        st_next;
    logic [3:0]        lat_hi;
    logic [DATA_W-1:0] lat_data;
    logic              lat_wr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_st <= BUS_IDLE;
        end else begin
            bus_st <= st_next;
        end
    end

    // next-state logic
    always_comb begin
        st_next = bus_st;
        unique case (bus_st)
            BUS_IDLE:   if (cpu_m2) st_next = BUS_ACTIVE;
            BUS_ACTIVE: if (!cpu_m2) st_next = lat_wr ? BUS_APPLY : BUS_IDLE;
            BUS_APPLY:  st_next = cpu_m2 ? BUS_ACTIVE : BUS_IDLE;
            default:    st_next = BUS_IDLE;
        endcase
    end

    // bus sampling while M2 is high; the last sample before the fall is kept
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_hi   <= '0;
            lat_data <= '0;
            lat_wr   <= 1'b0;
        end else if (cpu_m2) begin
            lat_hi   <= cpu_addr_hi;
            lat_data <= cpu_data;
            lat_wr   <= !cpu_rw;
        end
    end

    // output process: commit strobes only in the apply state
    always_comb begin
        sel_we  = 1'b0;
        data_we = 1'b0;
        wr_data = lat_data;
        unique case (bus_st)
            BUS_APPLY: begin
                sel_we  = (lat_hi == SEL_PAGE);
                data_we = lat_hi[3];
            end
            default: begin
                sel_we  = 1'b0;
                data_we = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/mmap_regfile.sv
module mmap_regfile
    import mmap_pkg::*;
#(
    parameter int INNER_W = 4,
    parameter int OUTER_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_we,
    input  logic               data_we,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [1:0]         sel_q,
    output logic [INNER_W-1:0] inner_q,
    output logic [3:0]         mode_q,
    output logic [OUTER_W-1:0] outer_q,
    output logic               inner_we,
    output logic               mode_we,
    output logic               outer_we
);

    reg_target_e target;
    assign target = reg_target_e'(sel_q);

    always_comb begin
        inner_we = 1'b0;
        mode_we  = 1'b0;
        outer_we = 1'b0;
        unique case (target)
            TGT_INNER: inner_we = data_we;
            TGT_MODE:  mode_we  = data_we;
            TGT_OUTER: outer_we = data_we;
            default:   ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= '1;
            inner_q <= '1;
            mode_q  <= '1;
            outer_q <= '1;
        end else begin
            if (sel_we)   sel_q   <= {wr_data[DATA_W-1], wr_data[0]};
            if (inner_we) inner_q <= wr_data[INNER_W-1:0];
            if (mode_we)  mode_q  <= wr_data[5:2];
            if (outer_we) outer_q <= wr_data[OUTER_W-1:0];
        end
    end

endmodule

// File: rtl/mmap_bank_calc.sv
module mmap_bank_calc
    import mmap_pkg::*;
#(
    parameter int BANK_W  = 8,
    parameter int INNER_W = 4
) (
    input  logic [3:0]         mode_q,
    input  logic [BANK_W-2:0]  outer_q,
    input  logic [INNER_W-1:0] inner_q,
    input  logic               a14,
    output logic [BANK_W-1:0]  rom_bank
);

    localparam int PAD32 = BANK_W - INNER_W - 1;
    localparam int PAD16 = BANK_W - INNER_W;

    logic [1:0]        size_sel;
    prg_mode_e         prg;
    logic [BANK_W-1:0] base;
    logic [BANK_W-1:0] pick;
    logic [BANK_W-1:0] inner_mask;
    logic [BANK_W-1:0] switched;
    logic              fixed_slot;

    assign size_sel = mode_q[3:2];
    assign prg      = prg_mode_e'(mode_q[1:0]);

    // bits replaced by the inner value: 1, 2, 3 or 4 low bits
    genvar gi;
    generate
        for (gi = 0; gi < BANK_W; gi++) begin : g_mask
            assign inner_mask[gi] = (gi <= int'(size_sel));
        end
    endgenerate

    always_comb begin
        base       = {outer_q, 1'b0};
        pick       = {{PAD16{1'b0}}, inner_q};
        fixed_slot = 1'b0;
        unique case (prg)
            PRG_32K_A, PRG_32K_B: begin
                pick       = {{PAD32{1'b0}}, inner_q, a14};
                fixed_slot = 1'b0;
            end
            PRG_FIX_LO: fixed_slot = !a14;
            PRG_FIX_HI: fixed_slot = a14;
            default:    fixed_slot = 1'b0;
        endcase
        switched = (base & ~inner_mask) | (pick & inner_mask);
        rom_bank = fixed_slot ? (base | {{(BANK_W-1){1'b0}}, a14}) : switched;
    end

endmodule

// File: rtl/multimode_prg_mapper.sv
module multimode_prg_mapper
    import mmap_pkg::*;
#(
    parameter int BANK_W  = 8,
    parameter int INNER_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        cpu_addr_hi,
    input  logic [7:0]        cpu_data,
    input  logic              cpu_rw,
    input  logic              cpu_m2,
    output logic [BANK_W-1:0] rom_bank
);

    localparam int OUTER_W = BANK_W - 1;

    bus_state_e         bus_st;
    logic               sel_we;
    logic               data_we;
    logic [DATA_W-1:0]  wr_data;
    logic [1:0]         sel_q;
    logic [INNER_W-1:0] inner_q;
    logic [3:0]         mode_q;
    logic [OUTER_W-1:0] outer_q;
    logic               inner_we;
    logic               mode_we;
    logic               outer_we;

    mmap_bus_fsm u_bus (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_addr_hi (cpu_addr_hi),
        .cpu_data    (cpu_data),
        .cpu_rw      (cpu_rw),
        .cpu_m2      (cpu_m2),
        .bus_st      (bus_st),
        .sel_we      (sel_we),
        .data_we     (data_we),
        .wr_data     (wr_data)
    );

    mmap_regfile #(
        .INNER_W (INNER_W),
        .OUTER_W (OUTER_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_we   (sel_we),
        .data_we  (data_we),
        .wr_data  (wr_data),
        .sel_q    (sel_q),
        .inner_q  (inner_q),
        .mode_q   (mode_q),
        .outer_q  (outer_q),
        .inner_we (inner_we),
        .mode_we  (mode_we),
        .outer_we (outer_we)
    );

    mmap_bank_calc #(
        .BANK_W  (BANK_W),
        .INNER_W (INNER_W)
    ) u_calc (
        .mode_q   (mode_q),
        .outer_q  (outer_q),
        .inner_q  (inner_q),
        .a14      (cpu_addr_hi[2]),
        .rom_bank (rom_bank)
    );

endmodule

// File: rtl/mmap_checker.sv
module mmap_checker
    import mmap_pkg::*;
#(
    parameter int BANK_W  = 8,
    parameter int INNER_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         a15_14,
    input logic               cpu_m2,
    input bus_state_e         bus_st,
    input logic               sel_we,
    input logic               inner_we,
    input logic               mode_we,
    input logic               outer_we,
    input logic [1:0]         sel_q,
    input logic [INNER_W-1:0] inner_q,
    input logic [3:0]         mode_q,
    input logic [BANK_W-2:0]  outer_q,
    input logic [BANK_W-1:0]  rom_bank
);

    // R1: out of reset the upper half shows the last bank
    a_r1_reset_last_bank: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_n) && a15_14 == 2'b11) |-> (rom_bank == '1));

    // R2: at most one register is written per commit
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_we, inner_we, mode_we, outer_we}));

    // R3: mode 3 upper half tracks the outer bank only
    a_r3_fixed_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[1:0] == 2'd3 && a15_14 == 2'b11) |-> (rom_bank == {outer_q, 1'b1}));

    // R4: mode 2 lower half tracks the outer bank only
    a_r4_fixed_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[1:0] == 2'd2 && a15_14 == 2'b10) |-> (rom_bank == {outer_q, 1'b0}));

    // R9: a commit always follows a sampled M2 fall out of the active state
    a_r9_apply_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_st == BUS_APPLY) |-> ($past(bus_st) == BUS_ACTIVE && !$past(cpu_m2)));

    // R9: registers hold outside the commit cycle
    a_r9_hold_between_commits: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_st != BUS_APPLY) |=> ($stable(sel_q) && $stable(inner_q) &&
                                   $stable(mode_q) && $stable(outer_q)));

endmodule

bind multimode_prg_mapper mmap_checker #(
    .BANK_W  (BANK_W),
    .INNER_W (INNER_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .a15_14   (cpu_addr_hi[3:2]),
    .cpu_m2   (cpu_m2),
    .bus_st   (bus_st),
    .sel_we   (sel_we),
    .inner_we (inner_we),
    .mode_we  (mode_we),
    .outer_we (outer_we),
    .sel_q    (sel_q),
    .inner_q  (inner_q),
    .mode_q   (mode_q),
    .outer_q  (outer_q),
    .rom_bank (rom_bank)
);

// File: tb/multimode_prg_mapper_tb_top.sv
module multimode_prg_mapper_tb_top;

    localparam int BANK_W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = 16'hFFFC;
    logic [7:0]  data = 8'h00;
    logic        rw = 1'b1;
    logic        m2 = 1'b0;
    logic [BANK_W-1:0] rom_bank;

    always #5 clk = ~clk;

    multimode_prg_mapper #(.BANK_W(BANK_W), .INNER_W(4)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_addr_hi (addr[15:12]),
        .cpu_data    (data),
        .cpu_rw      (rw),
        .cpu_m2      (m2),
        .rom_bank    (rom_bank)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench's own view of the registers, all ones after reset
    logic [1:0] m_sel   = 2'b11;
    logic [3:0] m_inner = 4'hF;
    logic [3:0] m_mode  = 4'hF;
    logic [6:0] m_outer = 7'h7F;

    typedef struct {
        logic [7:0]  exp;
        logic [15:0] a;
        string       tag;
    } item_t;

    item_t sb[$];
    event  ev;

    function automatic logic [7:0] exp_bank(input logic [3:0] md, input logic [6:0] ou,
                                            input logic [3:0] inn, input logic a14);
        logic [7:0] base;
        logic [7:0] r;
        logic [4:0] pick;
        logic       fixed;
        base  = {ou, 1'b0};
        fixed = (md[1:0] == 2'd2 && !a14) || (md[1:0] == 2'd3 && a14);
        pick  = (md[1:0] < 2'd2) ? {inn, a14} : {1'b0, inn};
        if (fixed) begin
            r = {base[7:1], a14};
        end else begin
            case (md[3:2])
                2'd0:    r = {base[7:1], pick[0]};
                2'd1:    r = {base[7:2], pick[1:0]};
                2'd2:    r = {base[7:3], pick[2:0]};
                default: r = {base[7:4], pick[3:0]};
            endcase
        end
        return r;
    endfunction

    task automatic push_exp(input logic [15:0] a, input string tag);
        item_t it;
        it.exp = exp_bank(m_mode, m_outer, m_inner, a[14]);
        it.a   = a;
        it.tag = tag;
        sb.push_back(it);
        -> ev;
    endtask

    task automatic probe(input logic [15:0] a, input string tag);
        @(negedge clk);
        addr = a;
        rw   = 1'b1;
        m2   = 1'b0;
        push_exp(a, tag);
    endtask

    // one M2 pulse; optional check while M2 is still high
    task automatic bus_cycle(input logic [15:0] a, input logic [7:0] d, input logic is_wr,
                             input bit mid_check, input string mtag);
        @(negedge clk);
        addr = a; data = d; rw = !is_wr; m2 = 1'b1;
        @(negedge clk);
        if (mid_check) push_exp(a, mtag);
        @(negedge clk);
        m2 = 1'b0;
        @(negedge clk);
        rw = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr_sel(input logic [7:0] v);
        bus_cycle(16'h5000, v, 1'b1, 1'b0, "");
        m_sel = {v[7], v[0]};
    endtask

    task automatic wr_reg(input logic [15:0] a, input logic [7:0] v, input bit mid, input string mtag);
        bus_cycle(a, v, 1'b1, mid, mtag);
        case (m_sel)
            2'b01:   m_inner = v[3:0];
            2'b10:   m_mode  = v[5:2];
            2'b11:   m_outer = v[6:0];
            default: ;
        endcase
    endtask

    // monitor: pops expected items and compares with the design output
    initial begin
        item_t it;
        forever begin
            @(ev);
            #1;
            while (sb.size() > 0) begin
                it = sb.pop_front();
                checks++;
                if (rom_bank !== it.exp) begin
                    fails++;
                    $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.a, rom_bank, it.exp);
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] outers [3];
        string tag;
        outers[0] = 8'h00;
        outers[1] = 8'h13;
        outers[2] = 8'hD5;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        probe(16'hC000, "R1");
        probe(16'h8000, "R1");

        // R2: selector resets to the outer bank; mode still all ones
        wr_reg(16'h8000, 8'h2A, 1'b0, "");
        probe(16'hC000, "R2");
        probe(16'h8000, "R2");

        // sweep of PRG modes, sizes, outer and inner values
        for (int p = 0; p < 4; p++) begin
            for (int s = 0; s < 4; s++) begin
                wr_sel(8'h80);
                wr_reg(16'h8000, {2'b00, s[1:0], p[1:0], 2'b11}, 1'b0, "");
                if (p < 2)       tag = "R5 R6 R12";
                else if (p == 2) tag = "R4 R6 R12";
                else             tag = "R3 R6 R12";
                for (int o = 0; o < 3; o++) begin
                    wr_sel(8'h81);
                    wr_reg(16'hA000, outers[o], 1'b0, "");
                    wr_sel(8'h01);
                    for (int i = 0; i < 16; i++) begin
                        wr_reg(16'hF123, {4'hA, i[3:0]}, 1'b0, "");
                        probe(16'h8765, tag);
                        probe(16'hC0DE, tag);
                    end
                end
            end
        end

        // R7: worked example, mode $3C outer $2A
        wr_sel(8'h80);
        wr_reg(16'h8000, 8'h3C, 1'b0, "");
        wr_sel(8'h81);
        wr_reg(16'h8000, 8'h2A, 1'b0, "");
        wr_sel(8'h01);
        for (int i = 0; i < 16; i++) begin
            wr_reg(16'h8000, i[7:0], 1'b0, "");
            probe(16'h8000, "R7");
            probe(16'hC000, "R7");
        end

        // R8: outer $2F gives bank $5F at $C000
        wr_sel(8'h81);
        wr_reg(16'h8000, 8'h2F, 1'b0, "");
        probe(16'hC000, "R8");

        // R10: $FF written where the ROM byte is $00
        wr_reg(16'hFFF6, 8'hFF, 1'b0, "");
        probe(16'hC000, "R10");

        // R13: outer bit 7 ignored
        wr_reg(16'hFFF6, 8'hAB, 1'b0, "");
        probe(16'hC000, "R13");

        // R9: bank unchanged while M2 high, changed after the fall
        wr_reg(16'hC000, 8'h11, 1'b1, "R9 mid-write");
        probe(16'hC000, "R9 after commit");

        // R9: read cycle, $6000 write and $4000 write change nothing
        bus_cycle(16'hC000, 8'h05, 1'b0, 1'b0, "");
        probe(16'hC000, "R9 read");
        bus_cycle(16'h6000, 8'h00, 1'b1, 1'b0, "");
        bus_cycle(16'hE000, 8'h3C, 1'b0, 1'b0, "");
        probe(16'hC000, "R9 6000");
        bus_cycle(16'h4000, 8'h01, 1'b1, 1'b0, "");
        wr_reg(16'hC000, 8'h22, 1'b0, "");
        probe(16'hC000, "R9 4000");

        // R11: selector 00 blocks data writes
        wr_sel(8'h00);
        wr_reg(16'h8000, 8'h00, 1'b0, "");
        probe(16'hC000, "R11");
        probe(16'h8000, "R11");
        wr_sel(8'h01);
        wr_reg(16'h8000, 8'h07, 1'b0, "");
        probe(16'h8000, "R11 restore");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule